// File: doc/BRIEF.md
# UART Register Front-End with Receive Queue

This block is the processor-facing register side of a serial port. A simple word-addressed bus reads and writes a small window of registers. Received characters come in from a line decoder over a valid/ready byte port and wait in a receive queue of up to 16 entries. Reading the data word returns the oldest character and removes it from the queue. Writing the data word hands one byte to the line encoder on a single-cycle transmit strobe.

Status flags, a two-source interrupt group and one interrupt line report the state of the queue. The interrupt group has a receive source and a transmit source. Each source has a raw bit, a mask bit and a write-one-to-clear word. Line, control, level-select and divisor holding words are plain storage for the neighbouring serial logic. The top eight words of the window return fixed identification bytes.

Bus accesses are single-cycle. Read data is combinational from the word address. Side effects of a read or write take effect at the clock edge that ends the access.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the flag word (6) reads 0x90, the control word (12) reads 0x300, the level-select word (13) reads 0x12, and every other storage, mask and status word reads 0. After reset `rx_ready_o` is 1 and `irq_o` and `tx_valid_o` are 0.
- R2: Bit 4 of the line word (11) enables the deep queue. With the bit set the block accepts up to 16 bytes; with it clear it accepts 1. `rx_ready_o` is low whenever the stored count has reached the current limit.
- R3: A read of word 0 returns the oldest stored byte in bits 7:0 with zeros above it, and removes that byte. Bytes come out in arrival order. A read of word 0 while the queue is empty leaves the count unchanged.
- R4: The flag word (6) is read-only and has these bits: bit 7 is always 1 (transmitter empty), bit 6 is 1 when the count equals 16, bit 5 is always 0, and bit 4 is 1 when the count is 0.
- R5: Raw interrupt bit 4 (receive) sets when an accepted byte brings the count to 1. It clears when a data read brings the count to 0.
- R6: A write to word 0 drives `tx_valid_o` high for exactly the next cycle, with `tx_data_o` equal to bits 7:0 of the written value. The same write sets raw interrupt bit 5 (transmit).
- R7: Word 14 is the mask (bits 5:4), word 15 reads the raw bits, and word 16 reads raw AND mask. Writing ones to bits 5:4 of word 17 clears those raw bits.
- R8: `irq_o` equals the OR of the masked status bits as they stood one cycle earlier.
- R9: Words 0x3F8 to 0x3FF read identification byte k (k = word − 0x3F8) of ID_VALUE in bits 7:0. With the default value, words 0x3F8, 0x3FB and 0x3FF read 0x18, 0x91 and 0x5A.
- R10: Words 8, 9, 10, 11, 12 and 13 read back the last 32-bit value written to them. Reads of unmapped words return 0. Writes to unmapped or read-only words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| waddr_i | input | 10 | Word address within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `waddr_i`, combinational |
| rx_valid_i | input | 1 | Received byte is offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Queue can accept a byte this cycle |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Queue pointers and the count are never visible directly. They show up in the data words returned, in the empty and full flags, and in `rx_ready_o`, all in the cycle right after the edge that changes them. A pointer slip appears on the first read that passes it, as a byte out of order. A count error appears one access later, as a wrong flag word or a missing or extra accepted byte at the limit. An interrupt source that sets or clears on the wrong event is visible in the raw status word right after the access, and on `irq_o` one cycle later.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned WORD_W = 10;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t W_DATA  = 10'd0;
  localparam word_t W_FLAG  = 10'd6;
  localparam word_t W_MASK  = 10'd14;
  localparam word_t W_RAW   = 10'd15;
  localparam word_t W_MSKD  = 10'd16;
  localparam word_t W_CLR   = 10'd17;

  // flag bit positions
  localparam int unsigned FLAG_TXE = 7;
  localparam int unsigned FLAG_RXF = 6;
  localparam int unsigned FLAG_TXF = 5;
  localparam int unsigned FLAG_RXE = 4;

  // interrupt group: register bit INT_LSB + index
  localparam int unsigned N_INT   = 2;
  localparam int unsigned INT_LSB = 4;
  localparam int unsigned IRQ_RX  = 0;
  localparam int unsigned IRQ_TX  = 1;

  localparam int unsigned LINE_QEN = 4;

  localparam int unsigned N_HOLD = 6;
  localparam int unsigned H_LINE = 3;
  localparam word_t       HOLD_WORD [N_HOLD] = '{10'd8, 10'd9, 10'd10, 10'd11, 10'd12, 10'd13};
  localparam logic [31:0] HOLD_RST  [N_HOLD] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h300, 32'h12};
endpackage

// File: rtl/uart_rf_rxfifo.sv
module uart_rf_rxfifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             ready_o,
  output logic             pushed_o,
  output logic             popped_o,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready_o  = cnt < limit_i;
  assign pushed_o = push_i & ready_o;
  assign popped_o = pop_i & (cnt != '0);
  assign head_o   = mem[rd_ptr];
  assign count_o  = cnt;

  always_ff @(posedge clk_i) begin
    if (pushed_o) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pushed_o) wr_ptr <= step(wr_ptr);
      if (popped_o) rd_ptr <= step(rd_ptr);
      case ({pushed_o, popped_o})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_INT-1:0] set_i,
  input  logic [N_INT-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [N_INT-1:0] mask_d_i,
  output logic [N_INT-1:0] raw_o,
  output logic [N_INT-1:0] mask_o,
  output logic             irq_o
);
  logic [N_INT-1:0] raw_q, mask_q;
  logic             irq_q;

  // set has priority over a same-cycle clear
  for (genvar i = 0; i < N_INT; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        raw_q[i] <= 1'b0;
      else if (set_i[i])  raw_q[i] <= 1'b1;
      else if (clr_i[i])  raw_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d_i;
      irq_q <= |(raw_q & mask_q);
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned RX_TRIG  = 1,
  parameter logic [63:0] ID_VALUE = 64'h5AC3_002E_9147_0618,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [9:0]  waddr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        irq_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  logic [31:0] hold_q [N_HOLD];
  for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              hold_q[g] <= HOLD_RST[g];
      else if (wr && waddr_i == HOLD_WORD[g])   hold_q[g] <= wdata_i;
    end
  end

  // receive queue
  logic             fifo_pop, fifo_push_ok, fifo_pop_ok;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] rx_cnt, rx_limit;

  assign fifo_pop = rd && waddr_i == W_DATA;
  assign rx_limit = hold_q[H_LINE][LINE_QEN] ? CNT_W'(DEPTH) : CNT_W'(1);

  uart_rf_rxfifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (rx_valid_i),
    .data_i   (rx_data_i),
    .pop_i    (fifo_pop),
    .limit_i  (rx_limit),
    .ready_o  (rx_ready_o),
    .pushed_o (fifo_push_ok),
    .popped_o (fifo_pop_ok),
    .head_o   (fifo_head),
    .count_o  (rx_cnt)
  );

  // interrupt events
  logic             rx_set, rx_hw_clr, tx_set, sw_clr;
  logic [N_INT-1:0] int_set, int_clr, int_raw, int_mask;

  assign rx_set    = fifo_push_ok & ~fifo_pop_ok & (rx_cnt == CNT_W'(RX_TRIG - 1));
  assign rx_hw_clr = fifo_pop_ok & ~fifo_push_ok & (rx_cnt == CNT_W'(RX_TRIG));
  assign tx_set    = wr && waddr_i == W_DATA;
  assign sw_clr    = wr && waddr_i == W_CLR;

  always_comb begin
    int_set = '0;
    int_set[IRQ_RX] = rx_set;
    int_set[IRQ_TX] = tx_set;
    int_clr = sw_clr ? wdata_i[INT_LSB +: N_INT] : '0;
    int_clr[IRQ_RX] = int_clr[IRQ_RX] | rx_hw_clr;
  end

  uart_rf_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (int_set),
    .clr_i     (int_clr),
    .mask_we_i (wr && waddr_i == W_MASK),
    .mask_d_i  (wdata_i[INT_LSB +: N_INT]),
    .raw_o     (int_raw),
    .mask_o    (int_mask),
    .irq_o     (irq_o)
  );

  // transmit strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= tx_set;
      if (tx_set) tx_data_o <= wdata_i[7:0];
    end
  end

  // read mux
  logic [7:0] flags;
  always_comb begin
    flags = '0;
    flags[FLAG_TXE] = 1'b1;
    flags[FLAG_RXF] = rx_cnt == CNT_W'(DEPTH);
    flags[FLAG_TXF] = 1'b0;
    flags[FLAG_RXE] = rx_cnt == '0;
  end

  logic       id_sel;
  logic [2:0] id_idx;
  assign id_sel = &waddr_i[9:3];
  assign id_idx = waddr_i[2:0];

  always_comb begin
    rdata_o = '0;
    if (id_sel) begin
      rdata_o[7:0] = ID_VALUE[8*id_idx +: 8];
    end else begin
      case (waddr_i)
        W_DATA: rdata_o[7:0] = fifo_head;
        W_FLAG: rdata_o[7:0] = flags;
        W_MASK: rdata_o[INT_LSB +: N_INT] = int_mask;
        W_RAW:  rdata_o[INT_LSB +: N_INT] = int_raw;
        W_MSKD: rdata_o[INT_LSB +: N_INT] = int_raw & int_mask;
        default: begin
          for (int g = 0; g < N_HOLD; g++)
            if (waddr_i == HOLD_WORD[g]) rdata_o = hold_q[g];
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_checker.sv
module uart_rf_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned N_INT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [9:0]       waddr_i,
  input logic [31:0]      wdata_i,
  input logic             rx_valid_i,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [N_INT-1:0] int_raw,
  input logic [N_INT-1:0] int_mask
);
  logic data_wr, data_rd;
  assign data_wr = req_i && we_i && waddr_i == 10'd0;
  assign data_rd = req_i && !we_i && waddr_i == 10'd0;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CNT_W'(DEPTH));

  assert_full_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt == CNT_W'(DEPTH) |-> !rx_ready_o);

  assert_push_counts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_ready_o && !data_rd |=> rx_cnt == $past(rx_cnt) + CNT_W'(1));

  assert_empty_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd && rx_cnt == '0 && !rx_valid_i |=> rx_cnt == '0);

  assert_tx_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> tx_valid_o && tx_data_o == $past(wdata_i[7:0]));

  assert_tx_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr |=> !tx_valid_o);

  assert_irq_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(int_raw & int_mask)) |=> irq_o);

  assert_irq_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(int_raw & int_mask)) |=> !irq_o);
endmodule

bind uart_regfront uart_rf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .N_INT(uart_rf_pkg::N_INT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .waddr_i    (waddr_i),
  .wdata_i    (wdata_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .irq_o      (irq_o),
  .rx_cnt     (rx_cnt),
  .int_raw    (int_raw),
  .int_mask   (int_mask)
);

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [9:0]  waddr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o, tx_valid_o, irq_o;
  logic [7:0]  tx_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_regfront u_uart_regfront (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .waddr_i(waddr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        we;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    // R1 reset values
    '{1'b0, 10'd6,  32'h0, 32'h90,  4'd1},
    '{1'b0, 10'd12, 32'h0, 32'h300, 4'd1},
    '{1'b0, 10'd13, 32'h0, 32'h12,  4'd1},
    '{1'b0, 10'd8,  32'h0, 32'h0,   4'd1},
    '{1'b0, 10'd11, 32'h0, 32'h0,   4'd1},
    '{1'b0, 10'd14, 32'h0, 32'h0,   4'd1},
    '{1'b0, 10'd15, 32'h0, 32'h0,   4'd1},
    '{1'b0, 10'd16, 32'h0, 32'h0,   4'd1},
    // R10 holding words
    '{1'b1, 10'd8,  32'hDEADBEEF, 32'h0, 4'd10},
    '{1'b0, 10'd8,  32'h0, 32'hDEADBEEF, 4'd10},
    '{1'b1, 10'd10, 32'h5, 32'h0, 4'd10},
    '{1'b0, 10'd10, 32'h0, 32'h5, 4'd10},
    '{1'b1, 10'd13, 32'h3F, 32'h0, 4'd10},
    '{1'b0, 10'd13, 32'h0, 32'h3F, 4'd10},
    '{1'b1, 10'd12, 32'h301, 32'h0, 4'd10},
    '{1'b0, 10'd12, 32'h0, 32'h301, 4'd10},
    // R10 unmapped
    '{1'b1, 10'd3,  32'hFFFF, 32'h0, 4'd10},
    '{1'b0, 10'd3,  32'h0, 32'h0, 4'd10},
    '{1'b0, 10'd30, 32'h0, 32'h0, 4'd10},
    // R4 flag word is read-only
    '{1'b1, 10'd6,  32'h0, 32'h0, 4'd4},
    '{1'b0, 10'd6,  32'h0, 32'h90, 4'd4},
    // R9 identification bytes
    '{1'b0, 10'h3F8, 32'h0, 32'h18, 4'd9},
    '{1'b0, 10'h3FB, 32'h0, 32'h91, 4'd9},
    '{1'b0, 10'h3FF, 32'h0, 32'h5A, 4'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [9:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    req_i = 1'b1; we_i = we; waddr_i = a; wdata_i = d;
    #1 q = rdata_o;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, output logic acc);
    rx_valid_i = 1'b1; rx_data_i = b;
    #1 acc = rx_ready_o;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic        acc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 port reset state
    chk("R1 rx_ready_o", 32'(rx_ready_o), 32'h1);
    chk("R1 irq_o", 32'(irq_o), 32'h0);
    chk("R1 tx_valid_o", 32'(tx_valid_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].we, VECS[i].a, VECS[i].d, q);
      if (!VECS[i].we) begin
        n_chk++;
        if (q !== VECS[i].e) begin
          n_bad++;
          $display("FAIL R%0d vector %0d word %h actual=%h expected=%h",
                   VECS[i].rq, i, VECS[i].a, q, VECS[i].e);
        end
      end
    end

    // R2 single-entry mode (line word bit 4 clear)
    push(8'h41, acc);  chk("R2 first byte accepted", 32'(acc), 32'h1);
    chk("R2 ready low at limit 1", 32'(rx_ready_o), 32'h0);
    bus(1'b0, 10'd6, '0, q);  chk("R4 flags one byte", q, 32'h80);
    bus(1'b0, 10'd15, '0, q); chk("R5 rx raw set", q, 32'h10);
    push(8'h42, acc);  chk("R2 second byte refused", 32'(acc), 32'h0);
    bus(1'b0, 10'd0, '0, q);  chk("R3 read byte", q, 32'h41);
    bus(1'b0, 10'd6, '0, q);  chk("R4 flags empty", q, 32'h90);
    bus(1'b0, 10'd15, '0, q); chk("R5 rx raw cleared by pop", q, 32'h0);

    // R2 deep mode
    bus(1'b1, 10'd11, 32'h10, q);
    for (int i = 0; i < 16; i++) begin
      push(8'(8'h60 + i), acc);
      chk("R2 deep accept", 32'(acc), 32'h1);
    end
    push(8'hEE, acc);  chk("R2 17th refused", 32'(acc), 32'h0);
    bus(1'b0, 10'd6, '0, q);  chk("R4 flags full", q, 32'hC0);
    bus(1'b0, 10'd15, '0, q); chk("R5 rx raw with 16", q, 32'h10);
    for (int i = 0; i < 16; i++) begin
      bus(1'b0, 10'd0, '0, q);
      chk("R3 arrival order", q, 32'(8'h60 + i));
      if (i == 14) begin
        bus(1'b0, 10'd15, '0, q); chk("R5 rx raw held at 1", q, 32'h10);
      end
    end
    bus(1'b0, 10'd6, '0, q);  chk("R4 flags drained", q, 32'h90);
    bus(1'b0, 10'd15, '0, q); chk("R5 rx raw after drain", q, 32'h0);
    // R3 read while empty keeps count
    bus(1'b0, 10'd0, '0, q);
    bus(1'b0, 10'd6, '0, q);  chk("R3 empty read no change", q, 32'h90);
    push(8'h77, acc);
    bus(1'b0, 10'd6, '0, q);  chk("R3 count one after empty read", q, 32'h80);

    // R7 software clear of rx raw
    bus(1'b1, 10'd17, 32'h10, q);
    bus(1'b0, 10'd15, '0, q); chk("R7 w1c rx", q, 32'h0);
    bus(1'b0, 10'd0, '0, q);  chk("R3 byte after clear", q, 32'h77);

    // R6 transmit
    bus(1'b1, 10'd0, 32'h1A5, q);
    chk("R6 tx_valid pulse", 32'(tx_valid_o), 32'h1);
    chk("R6 tx_data", 32'(tx_data_o), 32'hA5);
    @(negedge clk);
    chk("R6 tx_valid single cycle", 32'(tx_valid_o), 32'h0);
    bus(1'b0, 10'd15, '0, q); chk("R6 tx raw set", q, 32'h20);

    // R7/R8 mask and line timing
    bus(1'b1, 10'd14, 32'h20, q);
    chk("R8 irq not yet", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk("R8 irq asserted", 32'(irq_o), 32'h1);
    bus(1'b0, 10'd16, '0, q); chk("R7 masked status", q, 32'h20);
    bus(1'b0, 10'd14, '0, q); chk("R7 mask readback", q, 32'h20);
    bus(1'b1, 10'd17, 32'h20, q);
    chk("R8 irq held one cycle", 32'(irq_o), 32'h1);
    @(negedge clk);
    chk("R8 irq dropped", 32'(irq_o), 32'h0);
    bus(1'b0, 10'd15, '0, q); chk("R7 tx raw cleared", q, 32'h0);

    // R8 rx source through mask
    bus(1'b1, 10'd14, 32'h30, q);
    push(8'h12, acc);
    chk("R8 irq lags rx raw", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk("R8 irq from rx", 32'(irq_o), 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule